// File: doc/BRIEF.md
# Video RAM Block Copy Controller

This block moves data from the system address space into the 8 KiB video RAM window. Software sets a 16-bit source and a 16-bit destination through four byte-wide address registers, then writes a control register whose top bit picks the copy style. The low seven bits of that write give a block count, where each block is 16 bytes. In general-purpose style the whole length is copied in one burst. In line-gap style one 16-byte block is copied each time the video timing signals the start of a horizontal blanking gap.

While a burst runs, the block drives a read strobe toward the memory fabric and then a write strobe toward video RAM. It holds the processor stalled until the burst ends. When a burst finishes, the advanced pointers are stored back into the address registers. The control register then reports how many blocks are left, and it reads 0xFF once nothing is pending. A source that points into video RAM itself is refused and raises an error flag.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` are 0 source high byte, 1 source low byte, 2 destination high byte, 3 destination low byte and 4 control. Any other offset reads 0xFF. After reset the four address registers read 0x00, control reads 0xFF, and `cpu_stall`, `mem_rd_en`, `vram_we` and `src_err` are all low.
- R2: A control write takes the source as {source high, source low} with its low 4 bits forced to zero. If the result lies in 0x8000–0x9FFF, `src_err` goes high, no copy starts, and mode and length are unchanged. The next accepted control write clears `src_err`.
- R3: The destination is 0x8000 | ({destination high, destination low} & 0x1FF0). It advances by one per byte and wraps from 0x9FFF back to 0x8000.
- R4: A control write with bit 7 = 0 starts a copy of ((value & 0x7F) + 1) × 16 bytes on the next cycle, if no line-gap transfer was pending or if `vid_mode` is 0. If a line-gap transfer was pending and `vid_mode` is not 0, that transfer is cancelled, nothing is copied, and control reads {1, value[6:0]}.
- R5: Each byte takes exactly 2 cycles. In the first cycle `mem_rd_en` is high with `mem_rd_addr` set to the source. In the second cycle `vram_we` is high with `vram_wdata` set to the value `mem_rd_data` returns one cycle after the read. `cpu_stall` stays high for every cycle of a burst, and the source address increments by one per byte.
- R6: On the cycle after the last byte of a burst, the four address registers read back the advanced source and destination. The destination high byte includes the 0x80 base.
- R7: A control write with bit 7 = 1 arms line-gap mode. Each `hblank_start` pulse taken while armed and idle copies exactly 16 bytes. If `vid_mode` is 0 at the control write, the first block starts at once. Pulses are ignored while not armed.
- R8: While line-gap mode is armed, control reads {0, blocks remaining − 1}. Each finished block decrements this value. When it wraps to 0xFF the mode disarms. A finished general-purpose copy leaves control reading 0xFF.
- R9: Register writes that arrive while a burst is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read-back |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the register at `reg_addr` |
| vid_mode | input | 2 | Current video mode; 0 means inside the line gap |
| hblank_start | input | 1 | One-cycle pulse at the start of each line gap |
| mem_rd_en | output | 1 | Source read strobe |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Source data, valid one cycle after `mem_rd_en` |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 16 | Video RAM write address |
| vram_wdata | output | 8 | Video RAM write data |
| cpu_stall | output | 1 | Holds the processor while a burst runs |
| src_err | output | 1 | Last control write named a forbidden source |

## Verification
A control write or a line-gap pulse sampled at one edge puts `cpu_stall` and `mem_rd_en` high after that edge. `vram_we` follows one cycle later, and the data returned for that read lands on `vram_wdata` in the same cycle. The address registers and the control read-back take their new values on the cycle after the last write strobe. The bench keeps a behavioural model that applies each input at the same edge as the design. It compares every output and the read-back two nanoseconds after each falling edge, so register updates have settled and inputs are held still. Directed checks count stall cycles against twice the byte count and read back pointer and length values at the points named above.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BLK_SHIFT = 4;
    localparam int LEN_W     = 7;
    localparam int CNT_W     = LEN_W + BLK_SHIFT + 1;
    localparam int VOFS_W    = 13;
    localparam int NUM_AREGS = 4;

    localparam logic [ADDR_W-VOFS_W-1:0] VRAM_BASE = 3'b100;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [VOFS_W-1:0] dst;
    } xfer_ptr_t;

    function automatic logic [ADDR_W-1:0] align_src(input logic [DATA_W-1:0] hi,
                                                    input logic [DATA_W-1:0] lo);
        logic [ADDR_W-1:0] a;
        a = {hi, lo};
        a[BLK_SHIFT-1:0] = '0;
        return a;
    endfunction

    function automatic logic [VOFS_W-1:0] dst_offset(input logic [DATA_W-1:0] hi,
                                                     input logic [DATA_W-1:0] lo);
        logic [ADDR_W-1:0] a;
        a = {hi, lo};
        a[BLK_SHIFT-1:0] = '0;
        return a[VOFS_W-1:0];
    endfunction

    function automatic logic src_in_vram(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:VOFS_W] == VRAM_BASE;
    endfunction

endpackage

// File: rtl/vxfer_regs.sv
module vxfer_regs
    import vxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_src,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic [2:0]        rd_sel,
    input  logic [DATA_W-1:0] ctrl_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] src_cfg,
    output logic [VOFS_W-1:0] dst_cfg
);

    logic [DATA_W-1:0] areg_q [NUM_AREGS];
    logic [DATA_W-1:0] areg_d [NUM_AREGS];

    always_comb begin
        for (int i = 0; i < NUM_AREGS; i++) begin
            areg_d[i] = areg_q[i];
        end
        if (wb_en) begin
            areg_d[SEL_SRC_HI] = wb_src[ADDR_W-1:DATA_W];
            areg_d[SEL_SRC_LO] = wb_src[DATA_W-1:0];
            areg_d[SEL_DST_HI] = wb_dst[ADDR_W-1:DATA_W];
            areg_d[SEL_DST_LO] = wb_dst[DATA_W-1:0];
        end else if (wr_en && (wr_sel < 3'(NUM_AREGS))) begin
            areg_d[wr_sel[1:0]] = wr_data;
        end
    end

    generate
        for (genvar g = 0; g < NUM_AREGS; g++) begin : g_areg
            always_ff @(posedge clk) begin
                if (rst) begin
                    areg_q[g] <= '0;
                end else begin
                    areg_q[g] <= areg_d[g];
                end
            end
        end
    endgenerate

    assign src_cfg = align_src(areg_q[SEL_SRC_HI], areg_q[SEL_SRC_LO]);
    assign dst_cfg = dst_offset(areg_q[SEL_DST_HI], areg_q[SEL_DST_LO]);

    always_comb begin
        if (rd_sel < 3'(NUM_AREGS)) begin
            rdata = areg_q[rd_sel[1:0]];
        end else if (rd_sel == SEL_CTRL) begin
            rdata = ctrl_rdata;
        end else begin
            rdata = '1;
        end
    end

endmodule

// File: rtl/vxfer_engine.sv
module vxfer_engine
    import vxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_data,
    input  logic [ADDR_W-1:0] src_cfg,
    input  logic [VOFS_W-1:0] dst_cfg,
    input  logic [1:0]        vid_mode,
    input  logic              hblank_start,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              vram_we,
    output logic [ADDR_W-1:0] vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    output logic              busy,
    output logic              src_err,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_src,
    output logic [ADDR_W-1:0] wb_dst,
    output logic [DATA_W-1:0] ctrl_rdata
);

    xfer_state_e       state_q;
    xfer_ptr_t         ptr_q;
    logic [CNT_W-1:0]  left_q;
    logic              armed_q;
    logic [DATA_W-1:0] len_q;
    logic              err_q;

    logic              src_bad;
    logic              want_gap;
    logic              in_gap;
    logic              cfg_go;
    logic              gap_go;
    logic              last_byte;
    logic [LEN_W:0]    cfg_blocks;
    logic [CNT_W-1:0]  cfg_bytes;
    logic [CNT_W-1:0]  blk_bytes;

    always_comb begin
        src_bad    = src_in_vram(src_cfg);
        want_gap   = ctrl_data[DATA_W-1];
        in_gap     = (vid_mode == 2'd0);
        cfg_blocks = want_gap ? (LEN_W+1)'(1) : ({1'b0, ctrl_data[LEN_W-1:0]} + (LEN_W+1)'(1));
        cfg_bytes  = CNT_W'(cfg_blocks) << BLK_SHIFT;
        blk_bytes  = CNT_W'(1) << BLK_SHIFT;
        cfg_go     = ctrl_wr && !src_bad && (want_gap ? in_gap : (!armed_q || in_gap));
        gap_go     = (state_q == ST_IDLE) && armed_q && hblank_start && !ctrl_wr;
        last_byte  = (state_q == ST_STORE) && (left_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            left_q  <= '0;
            armed_q <= 1'b0;
            len_q   <= '1;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctrl_wr) begin
                        if (src_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q     <= 1'b0;
                            ptr_q.src <= src_cfg;
                            ptr_q.dst <= dst_cfg;
                            if (want_gap) begin
                                armed_q <= 1'b1;
                                len_q   <= {1'b0, ctrl_data[LEN_W-1:0]};
                            end else if (!armed_q || in_gap) begin
                                armed_q <= 1'b0;
                                len_q   <= {1'b0, ctrl_data[LEN_W-1:0]};
                            end else begin
                                armed_q <= 1'b0;
                                len_q   <= {1'b1, ctrl_data[LEN_W-1:0]};
                            end
                            if (cfg_go) begin
                                state_q <= ST_FETCH;
                                left_q  <= cfg_bytes;
                            end
                        end
                    end else if (gap_go) begin
                        state_q <= ST_FETCH;
                        left_q  <= blk_bytes;
                    end
                end
                ST_FETCH: begin
                    state_q <= ST_STORE;
                end
                ST_STORE: begin
                    ptr_q.src <= ptr_q.src + ADDR_W'(1);
                    ptr_q.dst <= ptr_q.dst + VOFS_W'(1);
                    left_q    <= left_q - CNT_W'(1);
                    if (last_byte) begin
                        state_q <= ST_IDLE;
                        if (armed_q) begin
                            len_q <= len_q - DATA_W'(1);
                            if (len_q == '0) begin
                                armed_q <= 1'b0;
                            end
                        end else begin
                            len_q <= '1;
                        end
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en   = (state_q == ST_FETCH);
    assign mem_rd_addr = ptr_q.src;
    assign vram_we     = (state_q == ST_STORE);
    assign vram_addr   = {VRAM_BASE, ptr_q.dst};
    assign vram_wdata  = mem_rd_data;
    assign busy        = (state_q != ST_IDLE);
    assign src_err     = err_q;
    assign wb_en       = last_byte;
    assign wb_src      = ptr_q.src + ADDR_W'(1);
    assign wb_dst      = {VRAM_BASE, ptr_q.dst + VOFS_W'(1)};
    assign ctrl_rdata  = armed_q ? {1'b0, len_q[LEN_W-1:0]} : len_q;

    // R5: a write strobe is always preceded by a read strobe
    a_r5_store_after_fetch: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> $past(mem_rd_en));

    // R5: the two strobes never overlap
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && vram_we));

    // R2: every burst begins on a 16-byte aligned source
    a_r2_aligned_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_rd_addr[BLK_SHIFT-1:0] == '0));

    // R2: a refused source never starts a burst
    a_r2_bad_src_no_start: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && src_bad && state_q == ST_IDLE) |=> !busy);

    // R3: consecutive video RAM writes step by one inside the window
    a_r3_dst_step: assert property (@(posedge clk) disable iff (rst)
        (vram_we && $past(vram_we, 2) && $past(busy)) |->
        (vram_addr[VOFS_W-1:0] == $past(vram_addr[VOFS_W-1:0], 2) + VOFS_W'(1)));

    // R8: a finished general-purpose copy reports 0xFF
    a_r8_gp_done_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(armed_q)) |-> (ctrl_rdata == 8'hFF));

endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
    import vxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [1:0]  vid_mode,
    input  logic        hblank_start,
    output logic        mem_rd_en,
    output logic [15:0] mem_rd_addr,
    input  logic [7:0]  mem_rd_data,
    output logic        vram_we,
    output logic [15:0] vram_addr,
    output logic [7:0]  vram_wdata,
    output logic        cpu_stall,
    output logic        src_err
);

    logic              busy;
    logic              acc_we;
    logic              ctrl_wr;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_src;
    logic [ADDR_W-1:0] wb_dst;
    logic [ADDR_W-1:0] src_cfg;
    logic [VOFS_W-1:0] dst_cfg;
    logic [DATA_W-1:0] ctrl_rdata;

    assign acc_we  = reg_we && !busy;
    assign ctrl_wr = acc_we && (reg_addr == SEL_CTRL);

    vxfer_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (acc_we),
        .wr_sel     (reg_addr),
        .wr_data    (reg_wdata),
        .wb_en      (wb_en),
        .wb_src     (wb_src),
        .wb_dst     (wb_dst),
        .rd_sel     (reg_addr),
        .ctrl_rdata (ctrl_rdata),
        .rdata      (reg_rdata),
        .src_cfg    (src_cfg),
        .dst_cfg    (dst_cfg)
    );

    vxfer_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_data    (reg_wdata),
        .src_cfg      (src_cfg),
        .dst_cfg      (dst_cfg),
        .vid_mode     (vid_mode),
        .hblank_start (hblank_start),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .vram_we      (vram_we),
        .vram_addr    (vram_addr),
        .vram_wdata   (vram_wdata),
        .busy         (busy),
        .src_err      (src_err),
        .wb_en        (wb_en),
        .wb_src       (wb_src),
        .wb_dst       (wb_dst),
        .ctrl_rdata   (ctrl_rdata)
    );

    assign cpu_stall = busy;

    // R9: a write while busy must not disturb the running burst
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_we && busy && !wb_en) |=> busy);

endmodule

// File: tb/vram_xfer_ctrl_bench.sv
module vram_xfer_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  vid_mode = 2'd3;
    logic        hblank_start = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'd0;
    logic        vram_we;
    logic [15:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic        cpu_stall;
    logic        src_err;

    int vecs = 0;
    int bad  = 0;
    int cyc  = 0;
    bit live = 0;

    always #4 clk = ~clk;

    vram_xfer_ctrl u_vram_xfer_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vid_mode(vid_mode),
        .hblank_start(hblank_start), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .cpu_stall(cpu_stall), .src_err(src_err)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // source memory stub: data returned one cycle after the read strobe
    always @(posedge clk) begin
        mem_rd_data <= mem_rd_en ? pattern(mem_rd_addr) : 8'h00;
    end

    // behavioural reference model
    logic [7:0]  m_reg [4];
    logic        m_busy, m_phase, m_hb, m_err;
    logic [15:0] m_src;
    logic [12:0] m_dst;
    int          m_left;
    logic [7:0]  m_len;

    task automatic m_start(input int nbytes);
        m_busy  = 1'b1;
        m_phase = 1'b0;
        m_left  = nbytes;
    endtask

    always @(posedge clk) begin
        logic [15:0] s;
        if (rst) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
            m_busy = 0; m_phase = 0; m_hb = 0; m_err = 0;
            m_src = 0; m_dst = 0; m_left = 0; m_len = 8'hFF;
        end else if (m_busy) begin
            if (!m_phase) begin
                m_phase = 1'b1;
            end else begin
                m_phase = 1'b0;
                m_src   = m_src + 16'd1;
                m_dst   = m_dst + 13'd1;
                m_left  = m_left - 1;
                if (m_left == 0) begin
                    m_busy   = 1'b0;
                    m_reg[0] = m_src[15:8];
                    m_reg[1] = m_src[7:0];
                    m_reg[2] = {3'b100, m_dst[12:8]};
                    m_reg[3] = m_dst[7:0];
                    if (m_hb) begin
                        if (m_len == 8'h00) m_hb = 1'b0;
                        m_len = m_len - 8'd1;
                    end else begin
                        m_len = 8'hFF;
                    end
                end
            end
        end else if (reg_we) begin
            if (reg_addr < 3'd4) begin
                m_reg[reg_addr[1:0]] = reg_wdata;
            end else if (reg_addr == 3'd4) begin
                s = {m_reg[0], m_reg[1] & 8'hF0};
                if (s >= 16'h8000 && s < 16'hA000) begin
                    m_err = 1'b1;
                end else begin
                    m_err = 1'b0;
                    m_src = s;
                    m_dst = {m_reg[2][4:0], m_reg[3] & 8'hF0};
                    if (reg_wdata[7]) begin
                        m_hb  = 1'b1;
                        m_len = {1'b0, reg_wdata[6:0]};
                        if (vid_mode == 2'd0) m_start(16);
                    end else if (!m_hb || vid_mode == 2'd0) begin
                        m_hb  = 1'b0;
                        m_len = {1'b0, reg_wdata[6:0]};
                        m_start((int'(reg_wdata[6:0]) + 1) * 16);
                    end else begin
                        m_hb  = 1'b0;
                        m_len = {1'b1, reg_wdata[6:0]};
                    end
                end
            end
        end else if (hblank_start && m_hb) begin
            m_start(16);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a);
        if (a < 3'd4) return m_reg[a[1:0]];
        if (a == 3'd4) return m_hb ? {1'b0, m_len[6:0]} : m_len;
        return 8'hFF;
    endfunction

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (live) begin
            chk("R5 cpu_stall", cpu_stall, m_busy);
            chk("R5 mem_rd_en", mem_rd_en, m_busy && !m_phase);
            chk("R5 vram_we", vram_we, m_busy && m_phase);
            chk("R2 src_err", src_err, m_err);
            chk("R8 reg_rdata", reg_rdata, m_read(reg_addr));
            if (m_busy && !m_phase) chk("R5 mem_rd_addr", mem_rd_addr, m_src);
            if (m_busy && m_phase) begin
                chk("R3 vram_addr", vram_addr, {3'b100, m_dst});
                chk("R5 vram_wdata", vram_wdata, pattern(m_src));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic stall_len(output int n);
        n = 0;
        while (cpu_stall) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        hblank_start = 1'b1;
        @(negedge clk);
        hblank_start = 1'b0;
    endtask

    task automatic idle_for(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            chk(tag, cpu_stall, 1'b0);
        end
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); chk("R1 addr reg reset", v, 8'h00);
        end
        rd(3'd4, v); chk("R1 ctrl reset", v, 8'hFF);
        rd(3'd6, v); chk("R1 unmapped offset", v, 8'hFF);
        chk("R1 no stall", cpu_stall, 1'b0);
        chk("R1 no error", src_err, 1'b0);

        // R4/R5/R6: general copy of two blocks
        wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h9A); wr(3'd3, 8'hBC);
        wr(3'd4, 8'h01);
        stall_len(n); chk("R4 R5 stall cycles 2x32", n, 64);
        rd(3'd0, v); chk("R6 src hi", v, 8'h12);
        rd(3'd1, v); chk("R6 src lo", v, 8'h50);
        rd(3'd2, v); chk("R6 dst hi", v, 8'h9A);
        rd(3'd3, v); chk("R6 dst lo", v, 8'hD0);
        rd(3'd4, v); chk("R8 gp done len", v, 8'hFF);

        // R3: destination wraps inside the window
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h01);
        stall_len(n); chk("R3 stall cycles", n, 64);
        rd(3'd2, v); chk("R3 dst hi after wrap", v, 8'h80);
        rd(3'd3, v); chk("R3 dst lo after wrap", v, 8'h10);

        // R2: forbidden source
        wr(3'd0, 8'h85); wr(3'd1, 8'h00); wr(3'd4, 8'h07);
        idle_for("R2 no start on bad source", 3);
        chk("R2 error flag set", src_err, 1'b1);
        rd(3'd4, v); chk("R2 len unchanged", v, 8'hFF);
        wr(3'd0, 8'h40); wr(3'd4, 8'h00);
        chk("R2 error cleared", src_err, 1'b0);
        stall_len(n); chk("R2 R4 single block", n, 32);

        // R7/R8: line-gap mode, three blocks, not in gap
        vid_mode = 2'd3;
        wr(3'd0, 8'h40); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'h82);
        idle_for("R7 armed waits for pulse", 3);
        rd(3'd4, v); chk("R8 armed len", v, 8'h02);
        pulse(); stall_len(n); chk("R7 block 1 size", n, 32);
        rd(3'd4, v); chk("R8 len after block 1", v, 8'h01);
        rd(3'd1, v); chk("R6 src lo after block 1", v, 8'h10);
        pulse(); stall_len(n); chk("R7 block 2 size", n, 32);
        rd(3'd4, v); chk("R8 len after block 2", v, 8'h00);
        pulse(); stall_len(n); chk("R7 block 3 size", n, 32);
        rd(3'd4, v); chk("R8 len wraps to FF", v, 8'hFF);
        pulse(); idle_for("R7 pulse ignored when disarmed", 3);

        // R4/R8: cancel a pending line-gap transfer
        wr(3'd4, 8'h85);
        rd(3'd4, v); chk("R8 armed len 5", v, 8'h05);
        wr(3'd4, 8'h03);
        idle_for("R4 cancel starts nothing", 3);
        rd(3'd4, v); chk("R8 cancel read", v, 8'h83);
        pulse(); idle_for("R7 pulse ignored after cancel", 3);

        // R7: immediate first block when inside the gap
        vid_mode = 2'd0;
        wr(3'd4, 8'h81);
        stall_len(n); chk("R7 immediate block", n, 32);
        rd(3'd4, v); chk("R8 len after immediate", v, 8'h00);
        pulse(); stall_len(n); chk("R7 last block", n, 32);
        rd(3'd4, v); chk("R8 done after last", v, 8'hFF);

        // R9: writes during a burst are ignored
        vid_mode = 2'd3;
        wr(3'd4, 8'h01);
        wr(3'd4, 8'h07);
        wr(3'd1, 8'hEE);
        stall_len(n); chk("R9 burst length unchanged", n, 64 - 4);
        rd(3'd4, v); chk("R9 ctrl write ignored", v, 8'hFF);
        rd(3'd1, v); chk("R9 src lo is writeback", v, 8'h70);
        idle_for("R9 no extra burst", 4);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule